// File: doc/BRIEF.md
# Power-Up Restart Sequencer

This block brings a halted processor back into operation after mains power returns. It imitates the console actions an operator would otherwise perform by hand. A rising edge on the power-up input starts it, but only while the restart-enable switch input is high. It then waits a long settle period so that every unit on the bus can finish its initialisation. After that it raises the load-path enables and clears the power-low flag. It issues two load strobes, switching into key-control mode between them, and finally pulses memory-start.

The first strobe writes the jumper-selected start address and forces the fetch state. The second strobe is issued with key-control active, so it writes zeros into the instruction-field and data-field registers instead. During each strobe the block pulls one data line low to form the start address. All delays are parameters counted in clock cycles. The defaults assume a 100 MHz clock, which gives a 1.5 s settle, a 250 ns gap and a 100 ns strobe.

Top module: `restart_seq`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), every output is low and the block stays idle until a new start condition.
- R2: A sequence starts only when `pwr_up_i` is high at a clock edge, `pwr_up_i` was low at the edge before, and `auto_en_i` is high. With `auto_en_i` low, nothing happens. A level held high through reset is not treated as an edge.
- R3: The start edge is followed by SETTLE_CYC cycles during which all outputs stay low.
- R4: When the settle period ends, `load_en_o`, `ind_inhibit_o` and `state_dis_o` rise in the same cycle. `pwr_low_clr_o` is high for exactly that first cycle.
- R5: The first `load_strobe_o` pulse begins GAP_CYC cycles after the enables rise and lasts STROBE_CYC cycles.
- R6: `key_ctl_o` rises in the cycle after the first strobe ends. The second strobe begins GAP_CYC cycles after the first strobe began and lasts STROBE_CYC cycles.
- R7: `data_low_o[k]` stands for data line k, where line 0 is the most significant address bit. During either strobe, select code 1 drives line 4 (address 0200 octal), code 2 drives line 2 (1000), code 3 drives line 1 (2000) and code 4 drives line 0 (4000). Codes 0 and 5 to 7 drive no line (0000). Outside the strobes all lines are released.
- R8: When the second strobe ends, `load_en_o`, `ind_inhibit_o`, `state_dis_o` and `key_ctl_o` fall together. FINAL_CYC cycles later, `mem_start_o` is high for START_CYC cycles, and then the block is idle.
- R9: A new rising edge on `pwr_up_i` while a sequence is running does not alter its timing.
- R10: Reset asserted in the middle of a sequence returns all outputs low at once, and no sequence resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_up_i | input | 1 | Power-good level from the line monitor |
| auto_en_i | input | 1 | Restart-enable switch |
| addr_sel_i | input | SEL_W | Start address select code |
| load_en_o | output | 1 | Load-path enable |
| ind_inhibit_o | output | 1 | Keeps console data off the bus |
| state_dis_o | output | 1 | Major-state disable |
| key_ctl_o | output | 1 | Key-control mode |
| load_strobe_o | output | 1 | Load strobe |
| data_low_o | output | DATA_W | Data lines pulled low (bit k = line k) |
| pwr_low_clr_o | output | 1 | One-cycle clear of the power-low flag |
| mem_start_o | output | 1 | Memory-start pulse |

## Verification
The bench builds the block with a 20-cycle settle, a 6-cycle gap, a 2-cycle strobe, a 5-cycle final delay and a 3-cycle start pulse. With these values a whole sequence takes about forty cycles, so every output can be compared cycle by cycle over the full run. This is done for all eight select codes. The short windows also make it cheap to inject a second power-up edge in both the settle and the enable phases, to reset in the middle of a strobe, and to hold the enable switch off.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_GAP1,
      ST_STRB1,
      ST_GAP2,
      ST_STRB2,
      ST_FINAL,
      ST_START
   } rs_state_e;
endpackage

// File: rtl/rs_countdown.sv
module rs_countdown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   if (W < 1) begin : g_bad_w
      $error("rs_countdown: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
endmodule

// File: rtl/rs_addr_pull.sv
module rs_addr_pull #(
   parameter int DATA_W = 12,
   parameter int SEL_W  = 3
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic              en,
   output logic [DATA_W-1:0] pull
);
   // select code that pulls a given data line; 0 means no code does
   function automatic int code_for_line(int line);
      case (line)
         4:       return 1;
         2:       return 2;
         1:       return 3;
         0:       return 4;
         default: return 0;
      endcase
   endfunction

   if (DATA_W < 5) begin : g_bad_dw
      $error("rs_addr_pull: DATA_W must be at least 5");
   end
   if (SEL_W < 3) begin : g_bad_sw
      $error("rs_addr_pull: SEL_W must be at least 3");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_line
      if (code_for_line(b) != 0) begin : g_used
         assign pull[b] = en && (sel == SEL_W'(code_for_line(b)));
      end else begin : g_unused
         assign pull[b] = 1'b0;
      end
   end

   always_comb begin
      AST_PULL_ONE_LINE: assert ($onehot0(pull)); // R7
   end
endmodule

// File: rtl/restart_seq.sv
module restart_seq
   import rs_pkg::*;
#(
   parameter int SETTLE_CYC = 150_000_000,
   parameter int GAP_CYC    = 25,
   parameter int STROBE_CYC = 10,
   parameter int FINAL_CYC  = 100,
   parameter int START_CYC  = 10,
   parameter int DATA_W     = 12,
   parameter int SEL_W      = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pwr_up_i,
   input  logic              auto_en_i,
   input  logic [SEL_W-1:0]  addr_sel_i,
   output logic              load_en_o,
   output logic              ind_inhibit_o,
   output logic              state_dis_o,
   output logic              key_ctl_o,
   output logic              load_strobe_o,
   output logic [DATA_W-1:0] data_low_o,
   output logic              pwr_low_clr_o,
   output logic              mem_start_o
);
   localparam int GAP2_CYC = GAP_CYC - STROBE_CYC;
   localparam int MAX_A    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
   localparam int MAX_B    = (FINAL_CYC > START_CYC) ? FINAL_CYC : START_CYC;
   localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   if (SETTLE_CYC < 1 || STROBE_CYC < 1 || FINAL_CYC < 1 || START_CYC < 1) begin : g_bad_len
      $error("restart_seq: every delay must be at least one cycle");
   end
   if (GAP_CYC <= STROBE_CYC) begin : g_bad_gap
      $error("restart_seq: GAP_CYC must exceed STROBE_CYC");
   end

   rs_state_e        state, nxt;
   logic             up_q, rise, clr_q;
   logic             ld, done;
   logic [CNT_W-1:0] ld_val;
   logic             in_strobe;

   assign rise = pwr_up_i && !up_q;

   always_comb begin
      nxt    = state;
      ld     = 1'b0;
      ld_val = '0;
      unique case (state)
         ST_IDLE:   if (rise && auto_en_i) begin nxt = ST_SETTLE; ld = 1'b1; ld_val = CNT_W'(SETTLE_CYC - 1); end
         ST_SETTLE: if (done) begin nxt = ST_GAP1;  ld = 1'b1; ld_val = CNT_W'(GAP_CYC - 1);    end
         ST_GAP1:   if (done) begin nxt = ST_STRB1; ld = 1'b1; ld_val = CNT_W'(STROBE_CYC - 1); end
         ST_STRB1:  if (done) begin nxt = ST_GAP2;  ld = 1'b1; ld_val = CNT_W'(GAP2_CYC - 1);   end
         ST_GAP2:   if (done) begin nxt = ST_STRB2; ld = 1'b1; ld_val = CNT_W'(STROBE_CYC - 1); end
         ST_STRB2:  if (done) begin nxt = ST_FINAL; ld = 1'b1; ld_val = CNT_W'(FINAL_CYC - 1);  end
         ST_FINAL:  if (done) begin nxt = ST_START; ld = 1'b1; ld_val = CNT_W'(START_CYC - 1);  end
         ST_START:  if (done) nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         up_q  <= 1'b1;
         clr_q <= 1'b0;
      end else begin
         state <= nxt;
         up_q  <= pwr_up_i;
         clr_q <= (state == ST_SETTLE) && done;
      end
   end

   rs_countdown #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (ld),
      .load_val (ld_val),
      .done     (done)
   );

   assign in_strobe     = (state == ST_STRB1) || (state == ST_STRB2);
   assign load_en_o     = (state == ST_GAP1) || (state == ST_STRB1) || (state == ST_GAP2) || (state == ST_STRB2);
   assign ind_inhibit_o = load_en_o;
   assign state_dis_o   = load_en_o;
   assign key_ctl_o     = (state == ST_GAP2) || (state == ST_STRB2);
   assign load_strobe_o = in_strobe;
   assign pwr_low_clr_o = clr_q;
   assign mem_start_o   = (state == ST_START);

   rs_addr_pull #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_pull (
      .sel  (addr_sel_i),
      .en   (in_strobe),
      .pull (data_low_o)
   );

   AST_STROBE_INSIDE_ENABLE: assert property (@(posedge clk) disable iff (rst)
      load_strobe_o |-> load_en_o); // R5
   AST_KEY_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
      $rose(key_ctl_o) |-> $past(load_strobe_o)); // R6
   AST_CLR_WITH_ENABLE: assert property (@(posedge clk) disable iff (rst)
      pwr_low_clr_o |-> (load_en_o && !load_strobe_o && !key_ctl_o)); // R4
   AST_DATA_ONLY_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
      (data_low_o != '0) |-> load_strobe_o); // R7
   AST_START_RELEASED: assert property (@(posedge clk) disable iff (rst)
      mem_start_o |-> (!load_en_o && !key_ctl_o && !load_strobe_o)); // R8
   AST_ENTRY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SETTLE && $past(state) != ST_SETTLE) |-> $past(state) == ST_IDLE); // R9
endmodule

// File: tb/restart_seq_tb.sv
module restart_seq_tb;
   localparam int S = 20, G = 6, P = 2, F = 5, M = 3;
   localparam int DW = 12, SW = 3;
   localparam int T = S + 2*G + P + F + M + 3;

   logic clk = 1'b0, rst = 1'b1;
   logic pwr_up = 1'b0, auto_en = 1'b1;
   logic [SW-1:0] sel = '0;
   logic le, ind, sd, key, stb, clr, mst;
   logic [DW-1:0] dl;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   restart_seq #(.SETTLE_CYC(S), .GAP_CYC(G), .STROBE_CYC(P), .FINAL_CYC(F),
                 .START_CYC(M), .DATA_W(DW), .SEL_W(SW)) u_dut (
      .clk(clk), .rst(rst), .pwr_up_i(pwr_up), .auto_en_i(auto_en), .addr_sel_i(sel),
      .load_en_o(le), .ind_inhibit_o(ind), .state_dis_o(sd), .key_ctl_o(key),
      .load_strobe_o(stb), .data_low_o(dl), .pwr_low_clr_o(clr), .mem_start_o(mst));

   function automatic logic [DW-1:0] pull_of(int code);
      case (code)
         1: return DW'(1) << 4;
         2: return DW'(1) << 2;
         3: return DW'(1) << 1;
         4: return DW'(1);
         default: return '0;
      endcase
   endfunction

   function automatic logic [DW+6:0] expect_at(int k, int code);
      logic e, kc, s, c, ms;
      e  = (k >= S) && (k < S + 2*G + P);
      kc = (k >= S + G + P) && (k < S + 2*G + P);
      s  = ((k >= S + G) && (k < S + G + P)) || ((k >= S + 2*G) && (k < S + 2*G + P));
      c  = (k == S);
      ms = (k >= S + 2*G + P + F) && (k < S + 2*G + P + F + M);
      return {e, e, e, kc, s, c, ms, s ? pull_of(code) : DW'(0)};
   endfunction

   function automatic string tag_at(int k);
      if (k < S) return "R3";
      if (k < S + G) return "R4";
      if (k < S + G + P) return "R5";
      if (k < S + 2*G) return "R6";
      if (k < S + 2*G + P) return "R7";
      return "R8";
   endfunction

   task automatic chk(string tag, logic [DW+6:0] exp);
      logic [DW+6:0] got;
      got = {le, ind, sd, key, stb, clr, mst, dl};
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic run_seq(int code, bit glitch);
      @(negedge clk);
      sel = SW'(code);
      pwr_up = 1'b1;
      @(posedge clk);
      for (int k = 0; k < T; k++) begin
         @(negedge clk);
         if (glitch && (k == 8 || k == S + 2)) pwr_up = 1'b0;
         if (glitch && (k == 9 || k == S + 3)) pwr_up = 1'b1;
         chk(glitch ? "R9" : tag_at(k), expect_at(k, code));
      end
      pwr_up = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", '0);

      for (int c = 0; c < 8; c++) run_seq(c, 1'b0);   // R7 all codes
      run_seq(3, 1'b1);                                // R9 extra edges

      // R2: switch off, edge ignored
      auto_en = 1'b0;
      @(negedge clk); pwr_up = 1'b1;
      for (int k = 0; k < S + 10; k++) begin @(negedge clk); chk("R2", '0); end
      pwr_up = 1'b0; auto_en = 1'b1;
      @(negedge clk);

      // R2: level held through reset is no edge
      pwr_up = 1'b1; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int k = 0; k < S + 10; k++) begin @(negedge clk); chk("R2", '0); end
      pwr_up = 1'b0;
      @(negedge clk);

      // R10: reset during first strobe
      @(negedge clk); sel = 3'd4; pwr_up = 1'b1;
      @(posedge clk);
      for (int k = 0; k < S + G + 1; k++) @(negedge clk);
      chk("R10", expect_at(S + G, 4));
      rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R10", '0);
      for (int k = 0; k < T; k++) begin @(negedge clk); chk("R10", '0); end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule